// File: doc/BRIEF.md
# SHA-256 Compression Core with Rolling Message Window

This core performs a single SHA-256 compression of one 512-bit message block against a 256-bit chaining value. It runs one round per clock. After 64 rounds it adds the working variables back into the chaining value and raises a one-cycle completion pulse. The updated chaining value stays on the output until the next command changes it. Hashing a message that spans several blocks means starting the core once per block. The chaining value carries over between blocks without any action from the user.

The message schedule is not held as a 64-entry array indexed by the round number. It lives in a 16-word window that shifts one place every round. The new schedule word is formed from four fixed window positions and enters at the top, while the word at the bottom feeds the current round and is then dropped. Schedule expansion therefore overlaps the rounds, and no read multiplexers hang off the storage.

The block arrives as eight 64-bit lanes. Each lane holds two schedule words in little-endian byte order. The chaining value is set either to the standard initial hash value or to a value supplied on a load port. Padding and block splitting are handled outside the core.

Top module: `sha256_roll_core`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `hash_o` is all zeros.
- R2: When the core is idle, `init_i` sets `hash_o` to the standard SHA-256 initial value on the next clock: 6a09e667 in bits 255:224 (word a) through 5be0cd19 in bits 31:0 (word h). This takes priority over `load_i` and `start_i` in the same cycle, and `start_i` is then ignored.
- R3: When idle and without `init_i`, `load_i` copies `state_i` to `hash_o` on the next clock. This takes priority over `start_i`.
- R4: Lane j of `block_i` is bits 64j+63:64j. Its low 32 bits, byte-reversed, form schedule word 2j, and its high 32 bits, byte-reversed, form schedule word 2j+1. Words are then read big-endian as in SHA-256. For the padded block of "abc" from the initial value, the result is ba7816bf...f20015ad.
- R5: On completion, each of the eight output words equals the old chaining word plus the matching working variable after 64 SHA-256 rounds, modulo 2^32. Successive blocks chain, so the 56-byte two-block test message gives 248d6a61...19db06c1.
- R6: `done_o` rises exactly 64 clock edges after the edge that accepts `start_i`. On the edge where `done_o` rises, `busy_o` falls, and a new start can be accepted in that same cycle.
- R7: `done_o` is high for exactly one cycle per accepted block.
- R8: While busy, `start_i` is ignored. No extra completion occurs, and the result belongs to the block that was accepted.
- R9: While busy, `init_i` and `load_i` are ignored, and `hash_o` stays stable until completion.
- R10: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load standard initial hash value (idle only) |
| load_i | input | 1 | Load chaining value from `state_i` (idle only) |
| state_i | input | 256 | Chaining value to load, word a in bits 255:224 |
| start_i | input | 1 | Begin compressing `block_i` |
| block_i | input | 512 | Message block as eight 64-bit lanes |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hash_o | output | 256 | Chaining value, word a in bits 255:224 |

## Verification
The assertions assume that `block_i` is sampled only on the accepting edge. They also assume that commands matter only when the core is idle, so a `state_i` change during a run is not a fault. The stimulus holds `block_i` steady on the accepting edge. It raises `start_i` only at idle or deliberately mid-run, and it drives `init_i`, `load_i` and `start_i` at the falling edge so each command is seen on exactly one rising edge. Mid-run commands land well inside the 64-round window, so they never coincide with the completion edge.

// File: rtl/sha_roll_pkg.sv
package sha_roll_pkg;
  localparam int WORD_W = 32;
  localparam int NWORD  = 8;
  localparam int ROUNDS = 64;
  localparam int WIN    = 16;
  localparam int LANE_W = 2 * WORD_W;
  localparam int NLANE  = WIN / 2;
  localparam int BLK_W  = NLANE * LANE_W;
  localparam int RND_W  = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NWORD-1:0] state_t;   // [7] = a ... [0] = h

  localparam word_t K_TAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam state_t IV_STATE = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sml0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t big0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic word_t byte_rev(input word_t x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
endpackage

// File: rtl/sha_roll_sched.sv
module sha_roll_sched
  import sha_roll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  word_t [WIN-1:0]   fill_words,
  input  logic              step_en,
  output word_t             head_w
);
  localparam int TAP_HI  = WIN - 2;
  localparam int TAP_MID = WIN - 7;
  localparam int TAP_LO  = 1;

  word_t [WIN-1:0] win_q;
  word_t [WIN-1:0] win_d;
  word_t [WIN-1:0] win_shift;
  word_t           grow_w;

  assign grow_w = sml1(win_q[TAP_HI]) + win_q[TAP_MID] + sml0(win_q[TAP_LO]) + win_q[0];

  for (genvar p = 0; p < WIN - 1; p++) begin : g_shift
    assign win_shift[p] = win_q[p+1];
  end
  assign win_shift[WIN-1] = grow_w;

  always_comb begin
    win_d = win_q;
    if (fill_en)      win_d = fill_words;
    else if (step_en) win_d = win_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 win_q <= '0;
    else if (fill_en || step_en) win_q <= win_d;
  end

  assign head_w = win_q[0];

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !fill_en) |=> (win_q[0] == $past(win_q[1])));
endmodule

// File: rtl/sha_roll_round.sv
module sha_roll_round
  import sha_roll_pkg::*;
(
  input  state_t cur_s,
  input  word_t  k_w,
  input  word_t  m_w,
  output state_t nxt_s
);
  word_t t1, t2;

  always_comb begin
    t1 = cur_s[0] + big1(cur_s[3]) + choose(cur_s[3], cur_s[2], cur_s[1]) + k_w + m_w;
    t2 = big0(cur_s[7]) + major(cur_s[7], cur_s[6], cur_s[5]);
    nxt_s[7] = t1 + t2;
    nxt_s[6] = cur_s[7];
    nxt_s[5] = cur_s[6];
    nxt_s[4] = cur_s[5];
    nxt_s[3] = cur_s[4] + t1;
    nxt_s[2] = cur_s[3];
    nxt_s[1] = cur_s[2];
    nxt_s[0] = cur_s[1];
  end
endmodule

// File: rtl/sha_roll_ctrl.sv
module sha_roll_ctrl
  import sha_roll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  output logic             busy_o,
  output logic             last_o,
  output logic             accept_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             done_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [RND_W-1:0] rnd_q, rnd_d;

  assign last_o   = busy_q && (rnd_q == LAST_RND);
  assign accept_o = !busy_q && start_ok;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      rnd_d  = '0;
    end else if (last_o) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      rnd_d  = rnd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign rnd_o  = rnd_q;
  assign done_o = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8
  rnd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));
  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!busy_q && $past(last_o)));
endmodule

// File: rtl/sha256_roll_core.sv
module sha256_roll_core
  import sha_roll_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_i,
  input  logic                  load_i,
  input  logic [NWORD*WORD_W-1:0] state_i,
  input  logic                  start_i,
  input  logic [BLK_W-1:0]      block_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [NWORD*WORD_W-1:0] hash_o
);
  logic             busy, last, accept;
  logic [RND_W-1:0] rnd;
  word_t [WIN-1:0]  fill_words;
  word_t            head_w;
  state_t           chain_q, chain_d, work_q, work_d, round_s;
  logic             chain_en, work_en;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    assign fill_words[2*j]   = byte_rev(block_i[LANE_W*j +: WORD_W]);
    assign fill_words[2*j+1] = byte_rev(block_i[LANE_W*j+WORD_W +: WORD_W]);
  end

  sha_roll_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_i && !init_i && !load_i),
    .busy_o   (busy),
    .last_o   (last),
    .accept_o (accept),
    .rnd_o    (rnd),
    .done_o   (done_o)
  );

  sha_roll_sched u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (accept),
    .fill_words (fill_words),
    .step_en    (busy),
    .head_w     (head_w)
  );

  sha_roll_round u_round (
    .cur_s (work_q),
    .k_w   (K_TAB[rnd]),
    .m_w   (head_w),
    .nxt_s (round_s)
  );

  always_comb begin
    chain_d  = chain_q;
    chain_en = 1'b0;
    if (!busy && init_i) begin
      chain_d  = IV_STATE;
      chain_en = 1'b1;
    end else if (!busy && load_i) begin
      chain_d  = state_i;
      chain_en = 1'b1;
    end else if (last) begin
      for (int n = 0; n < NWORD; n++) chain_d[n] = chain_q[n] + round_s[n];
      chain_en = 1'b1;
    end
  end

  always_comb begin
    work_en = accept || busy;
    work_d  = accept ? chain_q : round_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      work_q  <= '0;
    end else begin
      if (chain_en) chain_q <= chain_d;
      if (work_en)  work_q  <= work_d;
    end
  end

  assign busy_o = busy;
  assign hash_o = chain_q;

  // R2
  init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !busy) |=> (hash_o == IV_STATE));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !init_i && !busy) |=> (hash_o == $past(state_i)));
  // R9
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(hash_o));
endmodule

// File: tb/sha256_roll_core_bench.sv
module sha256_roll_core_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         init_i, load_i, start_i;
  logic [255:0] state_i;
  logic [511:0] block_i;
  logic         busy_o, done_o;
  logic [255:0] hash_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int start_cyc = 0;
  logic prev_done = 1'b0;
  logic finished = 1'b0;
  logic [255:0] exp_q[$];
  logic [255:0] model;

  always #4 clk = ~clk;

  sha256_roll_core u_sha256_roll_core (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .load_i(load_i), .state_i(state_i),
    .start_i(start_i), .block_i(block_i), .busy_o(busy_o), .done_o(done_o), .hash_o(hash_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] bs(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // reference compression with a full 64-entry schedule
  function automatic logic [255:0] ref_compress(input logic [255:0] st, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2, s0, s1;
    for (int j = 0; j < 8; j++) begin
      w[2*j]   = bs(blk[64*j +: 32]);
      w[2*j+1] = bs(blk[64*j+32 +: 32]);
    end
    for (int i = 16; i < 64; i++) begin
      s0 = rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3);
      s1 = rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10);
      w[i] = w[i-16] + s0 + w[i-7] + s1;
    end
    {a, b, c, d, e, f, g, h} = st;
    for (int i = 0; i < 64; i++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g))
           + sha_roll_pkg::K_TAB[i] + w[i];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    return {st[255:224] + a, st[223:192] + b, st[191:160] + c, st[159:128] + d,
            st[127:96] + e, st[95:64] + f, st[63:32] + g, st[31:0] + h};
  endfunction

  function automatic logic [511:0] pack16(input logic [31:0] w [16]);
    logic [511:0] r;
    for (int j = 0; j < 8; j++) begin
      r[64*j +: 32]    = bs(w[2*j]);
      r[64*j+32 +: 32] = bs(w[2*j+1]);
    end
    return r;
  endfunction

  function automatic logic [511:0] rand_blk();
    logic [511:0] r;
    for (int j = 0; j < 16; j++) r[32*j +: 32] = $urandom;
    return r;
  endfunction

  localparam logic [255:0] IV_EXP =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  // monitor: scoreboard pop on completion, latency and pulse width
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o && prev_done) chk(1'b0, "R7 done wider than one cycle", 256'd1, 256'd0);
      if (done_o && !prev_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected completion", hash_o, 256'd0);
        end else begin
          logic [255:0] e;
          e = exp_q.pop_front();
          chk(hash_o == e, "R5 digest", hash_o, e);
          chk((cyc - start_cyc) == 64, "R6 latency", 256'(cyc - start_cyc), 256'd64);
          chk(!busy_o, "R10 busy low at done", 256'(busy_o), 256'd0);
        end
      end
      prev_done <= done_o;
    end
  end

  task automatic do_init();
    @(negedge clk); init_i = 1'b1;
    @(negedge clk); init_i = 1'b0;
    model = IV_EXP;
  endtask

  task automatic do_load(input logic [255:0] v);
    @(negedge clk); load_i = 1'b1; state_i = v;
    @(negedge clk); load_i = 1'b0;
    model = v;
  endtask

  // driver: start a block, push expected result, wait for completion
  task automatic run_blk(input logic [511:0] blk);
    @(negedge clk);
    block_i = blk; start_i = 1'b1;
    model = ref_compress(model, blk);
    exp_q.push_back(model);
    @(posedge clk); #1 start_cyc = cyc;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o, "R10 busy after start", 256'(busy_o), 256'd1);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    logic [31:0] w [16];
    logic [255:0] held;
    string msg;
    rst_n = 1'b0; init_i = 0; load_i = 0; start_i = 0; state_i = '0; block_i = '0;
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o, "R1 control after reset", {busy_o, done_o}, 256'd0);
    chk(hash_o == '0, "R1 hash after reset", hash_o, 256'd0);

    // R2 init
    do_init();
    chk(hash_o == IV_EXP, "R2 init value", hash_o, IV_EXP);

    // R4 "abc" block
    for (int i = 0; i < 16; i++) w[i] = '0;
    w[0] = 32'h61626380; w[15] = 32'h00000018;
    run_blk(pack16(w));
    chk(hash_o == 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad,
        "R4 abc known answer", hash_o,
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad);

    // R5 two-block chaining known answer
    do_init();
    msg = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
    for (int i = 0; i < 14; i++) w[i] = {msg[4*i], msg[4*i+1], msg[4*i+2], msg[4*i+3]};
    w[14] = 32'h80000000; w[15] = 32'h0;
    run_blk(pack16(w));
    for (int i = 0; i < 16; i++) w[i] = '0;
    w[15] = 32'h000001c0;
    run_blk(pack16(w));
    chk(hash_o == 256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1,
        "R5 two-block known answer", hash_o,
        256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1);

    // R3 load, then random blocks, some back to back
    do_load({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    chk(hash_o == model, "R3 load value", hash_o, model);
    for (int n = 0; n < 4; n++) run_blk(rand_blk());

    // R8 / R9 commands during a run
    @(negedge clk);
    block_i = rand_blk(); start_i = 1'b1;
    model = ref_compress(model, block_i);
    exp_q.push_back(model);
    @(posedge clk); #1 start_cyc = cyc;
    @(negedge clk); start_i = 1'b0;
    held = hash_o;
    repeat (10) @(negedge clk);
    block_i = rand_blk(); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; init_i = 1'b1;
    @(negedge clk); init_i = 1'b0; load_i = 1'b1; state_i = ~held;
    @(negedge clk); load_i = 1'b0;
    chk(busy_o, "R8 still busy after mid-run start", 256'(busy_o), 256'd1);
    chk(hash_o == held, "R9 hash stable mid-run", hash_o, held);
    while (busy_o) @(negedge clk);
    chk(hash_o == model, "R9 result unaffected", hash_o, model);
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R8 no extra run", 256'(busy_o), 256'd0);

    // R2 priority: init with start leaves core idle
    @(negedge clk); init_i = 1'b1; start_i = 1'b1;
    @(negedge clk); init_i = 1'b0; start_i = 1'b0;
    model = IV_EXP;
    chk(!busy_o, "R2 start ignored with init", 256'(busy_o), 256'd0);
    chk(hash_o == IV_EXP, "R2 init wins", hash_o, IV_EXP);
    // R3 priority: load with start leaves core idle
    @(negedge clk); load_i = 1'b1; start_i = 1'b1; state_i = 256'h5a;
    @(negedge clk); load_i = 1'b0; start_i = 1'b0;
    chk(!busy_o && hash_o == 256'h5a, "R3 load wins over start", hash_o, 256'h5a);
    model = 256'h5a;
    run_blk(rand_blk());

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule